// File: doc/BRIEF.md
# Iterative Integer Multiplier with Four Result Selections

This block multiplies two operands of XLEN bits over XLEN clock cycles and returns one XLEN-bit slice of the 2*XLEN-bit product. A two-bit selector chooses the slice and how the operands are read. The lower half of the product is available, and the upper half is available in three forms: both operands signed, both operands unsigned, or the first operand signed and the second unsigned. All four come from one shift-and-add datapath. Software can use an upper-half result to tell whether a product overflowed XLEN bits.

A request is made by raising `start` for one cycle while `busy` is low. The operands and the selector are captured at that clock edge. Signed operands are turned into magnitudes before the iteration. The iteration looks at one multiplier bit per cycle, starting at the least significant bit. When that bit is 1, it adds a double-width multiplicand, which shifts left each cycle. When the iteration ends, the product is negated if the operand signs differ. The selected half is then registered to `result`, and `done` is raised.

Top module: `seq_mul_top`

## Requirements
- R1: While `rst_n` is low and after reset, `busy` and `done` are 0 and `result` is 0.
- R2: A `start` seen at a clock edge while `busy` is low begins an operation. `busy` is then high for exactly XLEN cycles. `done` is high for exactly one cycle, the cycle right after the last busy cycle.
- R3: Selector 2'b00 returns bits XLEN-1:0 of the product of `rs1` and `rs2`.
- R4: Selector 2'b01 returns bits 2*XLEN-1:XLEN of the product, with both operands read as two's-complement signed values.
- R5: Selector 2'b10 returns bits 2*XLEN-1:XLEN of the product, with `rs1` read as signed and `rs2` read as unsigned.
- R6: Selector 2'b11 returns bits 2*XLEN-1:XLEN of the product, with both operands read as unsigned.
- R7: A `start` while `busy` is high is ignored. The running operation keeps its operands, its selector and its XLEN-cycle length.
- R8: `result` changes only in the cycle that `done` is high. It holds its value through idle cycles and through the whole of the next operation.
- R9: Changes to `rs1`, `rs2` and `op` after the accepting edge have no effect on the running operation.
- R10: The most negative value, zero and all-ones operands give the exact results. For example, the signed upper half of (-2^(XLEN-1)) squared is 2^(XLEN-2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a multiply; accepted only while idle |
| op | input | 2 | Result selector: 00 low, 01 high s*s, 10 high s*u, 11 high u*u |
| rs1 | input | XLEN | First operand (multiplicand) |
| rs2 | input | XLEN | Second operand (multiplier) |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | XLEN | Selected product half; held until the next completion |

## Verification
The bench builds the block with its default XLEN of 32. At that width a 64-bit integer in the bench holds the exact product for every selector, including the signed-by-unsigned case, whose magnitude stays below 2^63. The bench therefore checks the unsigned magnitude path, the final negation and the half selection on every combination of the most negative value, zero, one and all-ones operands, plus random operands. Timing is checked at the same width: the 32-cycle busy window, a start arriving in the middle of an operation, and operand changes after acceptance.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    MUL_LO     = 2'b00,
    MUL_HI_SS  = 2'b01,
    MUL_HI_SU  = 2'b10,
    MUL_HI_UU  = 2'b11
  } mul_sel_e;
endpackage

// File: rtl/mul_operand_prep.sv
module mul_operand_prep
  import mul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  mul_sel_e          sel,
  input  logic [XLEN-1:0]   opa,
  input  logic [XLEN-1:0]   opb,
  output logic [XLEN-1:0]   mag_a,
  output logic [XLEN-1:0]   mag_b,
  output logic              flip
);
  // Magnitude of a value that may be read as signed
  function automatic logic [XLEN-1:0] magnitude(input logic [XLEN-1:0] v, input logic is_signed);
    if (is_signed && v[XLEN-1]) return (~v) + XLEN'(1);
    return v;
  endfunction

  logic a_signed, b_signed, a_neg, b_neg;

  always_comb begin
    a_signed = (sel == MUL_HI_SS) || (sel == MUL_HI_SU);
    b_signed = (sel == MUL_HI_SS);
    a_neg    = a_signed && opa[XLEN-1];
    b_neg    = b_signed && opb[XLEN-1];
    mag_a    = magnitude(opa, a_signed);
    mag_b    = magnitude(opb, b_signed);
    flip     = a_neg ^ b_neg;
  end
endmodule

// File: rtl/mul_shift_add_core.sv
module mul_shift_add_core #(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [XLEN-1:0]   mcand_init,
  input  logic [XLEN-1:0]   mplier_init,
  output logic              busy,
  output logic              last_step,
  output logic [2*XLEN-1:0] prod_next
);
  localparam int PW = 2 * XLEN;
  localparam int CW = (XLEN > 1) ? $clog2(XLEN) : 1;

  logic [PW-1:0]   mcand_q;
  logic [PW-1:0]   prod_q;
  logic [XLEN-1:0] mplier_q;
  logic [CW-1:0]   step_q;

  // One iteration of the shift-and-add recurrence
  function automatic logic [PW-1:0] accumulate(input logic [PW-1:0] acc,
                                               input logic [PW-1:0] addend,
                                               input logic bit_in);
    return bit_in ? acc + addend : acc;
  endfunction

  assign last_step = busy && (step_q == CW'(XLEN - 1));
  assign prod_next = accumulate(prod_q, mcand_q, mplier_q[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      step_q   <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      prod_q   <= '0;
    end else if (load) begin
      busy     <= 1'b1;
      step_q   <= '0;
      mcand_q  <= {{XLEN{1'b0}}, mcand_init};
      mplier_q <= mplier_init;
      prod_q   <= '0;
    end else if (busy) begin
      prod_q   <= prod_next;
      mcand_q  <= mcand_q << 1;
      mplier_q <= mplier_q >> 1;
      step_q   <= step_q + CW'(1);
      if (last_step) busy <= 1'b0;
    end
  end

  // R2: each busy cycle advances the step count by one
  p_step_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step && !load) |=> (busy && step_q == $past(step_q) + CW'(1)));
  // R2: an accepted load starts at step zero
  p_load_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy && step_q == '0));
  // R2: by the final step only one multiplier bit is left to examine
  p_mplier_drained_r2: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |-> ((mplier_q >> 1) == '0));
  // R7: the top never asks for a load while an iteration is running
  p_no_load_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load);
endmodule

// File: rtl/mul_result_sel.sv
module mul_result_sel
  import mul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  mul_sel_e          sel,
  input  logic              flip,
  input  logic [2*XLEN-1:0] prod,
  output logic [XLEN-1:0]   res
);
  localparam int PW = 2 * XLEN;

  function automatic logic [PW-1:0] apply_sign(input logic [PW-1:0] p, input logic neg);
    return neg ? (~p) + PW'(1) : p;
  endfunction

  logic [PW-1:0] signed_prod;

  always_comb begin
    signed_prod = apply_sign(prod, flip);
    res = (sel == MUL_LO) ? signed_prod[XLEN-1:0] : signed_prod[PW-1:XLEN];
  end
endmodule

// File: rtl/seq_mul_top.sv
module seq_mul_top
  import mul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      op,
  input  logic [XLEN-1:0] rs1,
  input  logic [XLEN-1:0] rs2,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result
);
  logic              accept;
  logic [XLEN-1:0]   mag_a, mag_b, res_next;
  logic              flip_in, flip_q, last_step;
  logic [2*XLEN-1:0] prod_next;
  mul_sel_e          sel_in, sel_q;

  assign sel_in = mul_sel_e'(op);
  assign accept = start && !busy;

  mul_operand_prep #(.XLEN(XLEN)) u_prep (
    .sel   (sel_in),
    .opa   (rs1),
    .opb   (rs2),
    .mag_a (mag_a),
    .mag_b (mag_b),
    .flip  (flip_in)
  );

  mul_shift_add_core #(.XLEN(XLEN)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (accept),
    .mcand_init  (mag_a),
    .mplier_init (mag_b),
    .busy        (busy),
    .last_step   (last_step),
    .prod_next   (prod_next)
  );

  mul_result_sel #(.XLEN(XLEN)) u_sel (
    .sel  (sel_q),
    .flip (flip_q),
    .prod (prod_next),
    .res  (res_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= MUL_LO;
      flip_q <= 1'b0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      if (accept) begin
        sel_q  <= sel_in;
        flip_q <= flip_in;
      end
      done <= last_step;
      if (last_step) result <= res_next;
    end
  end

  // R2: done lasts exactly one cycle
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: done follows the final busy cycle
  p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R8: result moves only together with done
  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
  // R7: a start during busy leaves the captured request alone
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(sel_q) && $stable(flip_q)));
endmodule

// File: tb/tb_seq_mul_top.sv
module tb_seq_mul_top;
  localparam int XLEN = 32;
  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [1:0]      op = 2'b00;
  logic [XLEN-1:0] rs1 = '0;
  logic [XLEN-1:0] rs2 = '0;
  logic            busy, done;
  logic [XLEN-1:0] result;

  int checks = 0;
  int fails  = 0;

  seq_mul_top #(.XLEN(XLEN)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .rs1(rs1), .rs2(rs2), .busy(busy), .done(done), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference: exact product in 64-bit arithmetic, then pick a half
  function automatic logic [31:0] expect_res(input logic [1:0] sel, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] uu;
    longint      sp;
    uu = {32'b0, a} * {32'b0, b};
    case (sel)
      2'b00: return uu[31:0];
      2'b01: begin sp = longint'($signed(a)) * longint'($signed(b)); return sp[63:32]; end
      2'b10: begin sp = longint'($signed(a)) * longint'({32'b0, b}); return sp[63:32]; end
      default: return uu[63:32];
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] sel);
    case (sel)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Runs one operation; optional start pulse mid-flight (R7) and input scrambling (R9)
  task automatic run(input logic [1:0] sel, input logic [31:0] a, input logic [31:0] b,
                     input bit poke_start, input string tag);
    logic [31:0] prev;
    int          busy_cnt;
    prev = result;
    @(negedge clk);
    start = 1'b1; op = sel; rs1 = a; rs2 = b;
    @(negedge clk);
    start = 1'b0;
    rs1 = ~a; rs2 = b ^ 32'h5a5a_5a5a; op = ~sel;           // R9: inputs move after acceptance
    check("R8", "result held during next op", {32'b0, result}, {32'b0, prev});
    busy_cnt = 0;
    while (!done && busy_cnt < 100) begin
      if (busy) busy_cnt++;
      if (poke_start && busy_cnt == 10) start = 1'b1;          // R7: start while busy
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check("R2", "busy cycle count", 64'(busy_cnt), 64'(XLEN));
    check("R2", "busy low with done", {63'b0, busy}, 64'd0);
    check(tag, "result", {32'b0, result}, {32'b0, expect_res(sel, a, b)});
    if (poke_start)
      check("R7", "mid-run start ignored", {32'b0, result}, {32'b0, expect_res(sel, a, b)});
    prev = result;
    @(negedge clk);
    check("R2", "done pulse one cycle", {63'b0, done}, 64'd0);
    @(negedge clk);
    check("R8", "result held while idle", {32'b0, result}, {32'b0, prev});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] corners [6];
    int unsigned seed_v;
    corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001; corners[2] = 32'h8000_0000;
    corners[3] = 32'hffff_ffff; corners[4] = 32'h7fff_ffff; corners[5] = 32'h1234_5678;
    seed_v = $urandom(32'd20240);

    repeat (3) @(negedge clk);
    check("R1", "busy in reset", {63'b0, busy}, 64'd0);
    check("R1", "done in reset", {63'b0, done}, 64'd0);
    check("R1", "result in reset", {32'b0, result}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "busy after reset", {63'b0, busy}, 64'd0);

    // R10 directed corners
    run(2'b01, 32'h8000_0000, 32'h8000_0000, 1'b0, "R10");
    check("R10", "min*min signed high", {32'b0, result}, 64'h4000_0000);
    run(2'b10, 32'hffff_ffff, 32'hffff_ffff, 1'b0, "R10");
    check("R10", "-1 * 0xffffffff su high", {32'b0, result}, 64'hffff_ffff);
    run(2'b11, 32'hffff_ffff, 32'hffff_ffff, 1'b0, "R10");
    check("R10", "all-ones uu high", {32'b0, result}, 64'hffff_fffe);
    run(2'b00, 32'h8000_0000, 32'h0000_0000, 1'b0, "R10");

    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int s = 0; s < 4; s++)
          run(2'(s), corners[i], corners[j], (i + j + s) % 7 == 0, req_of(2'(s)));

    for (int k = 0; k < 120; k++) begin
      logic [1:0] s;
      s = 2'($urandom_range(0, 3));
      run(s, $urandom, $urandom, (k % 5) == 0, req_of(s));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule